// File: doc/BRIEF.md
# Two-Level Page Table Walker with Bypass Windows

This unit turns a 32-bit virtual address into a 34-bit physical address for one of three access kinds: instruction fetch, data load or data store. A request is accepted through a valid/ready pair. The unit then decides whether translation applies at all. Translation is skipped when the control word has paging switched off, when the address lies at or above the page-table region, or when the address falls inside the boot window. A skipped request returns the input address unchanged.

Otherwise the unit walks a two-level table held in memory, one 32-bit entry per level, through a read port with a grant and a separate data-valid. The root table's page number comes from the control word. Each entry is checked for validity, for whether it points to a further level, and for the permission the access kind needs. The result is either a physical address or a fault with a 2-bit cause code. Every leaf maps a 4 KiB page, including a leaf found at the upper level.

The control word is sampled when a request is accepted. Only one request is in flight at a time, and each request is answered by a single-cycle response strobe.

Top module: `xlate_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_req` are 0.
- R2: When `ctl_word` bit 31 is 0 (paging off), the response is the input address zero-extended, with `rsp_fault`=0 and no memory read. `rsp_valid` rises at the first rising edge after the accepting edge.
- R3: With paging on, an address is passed through untranslated without any memory read in two cases: the address is at or above `PT_BASE`, or it lies in the half-open window [`BOOT_BASE`, `BOOT_BASE`+`BOOT_SPAN`). Addresses just outside these bounds are translated.
- R4: The first entry read is at (`ctl_word`[21:0] << 12) + VA[31:22]*4.
- R5: An entry with V=1 and R=W=X=0 read at the upper level is a pointer. The second read is then at (entry[31:10] << 12) + VA[21:12]*4.
- R6: A leaf at either level gives `rsp_paddr` = (entry[31:10] << 12) | VA[11:0]. Entry flag bits are V=bit0, R=bit1, W=bit2 and X=bit3.
- R7: An entry with V=0, or with R=0 and W=1, ends the walk with `rsp_fault`=1 and cause 0.
- R8: A pointer entry found at the lower level ends the walk with `rsp_fault`=1 and cause 1, after exactly two reads.
- R9: At a leaf, a fetch (kind 0) needs R and X, a load (kind 1) needs R, and a store (kind 2) needs W. Kind 3 is handled as a load. A violation gives `rsp_fault`=1, cause 2 and `rsp_paddr`=0.
- R10: `mem_req` stays high with a stable `mem_addr` until `mem_gnt`. After a grant, the entry is taken only when `mem_rvalid` is high. `mem_req` is never high while the unit is idle.
- R11: Each accepted request gets exactly one single-cycle `rsp_valid` pulse. `req_ready` is 0 from acceptance through the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 treated as load |
| ctl_word | input | 32 | Control word: bit 31 enables paging, bits 21:0 give the root page number |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_paddr | output | 34 | Physical address (0 on a fault) |
| rsp_fault | output | 1 | The walk ended in a fault |
| rsp_cause | output | 2 | Fault cause: 0 invalid entry, 1 no leaf, 2 permission |
| mem_req | output | 1 | Entry read request |
| mem_addr | output | 34 | Entry physical address |
| mem_gnt | input | 1 | Read request accepted |
| mem_rvalid | input | 1 | Entry data valid |
| mem_rdata | input | 32 | Entry data |

## Verification
The cases that are hardest to reach from the ports depend on what memory returns rather than on the request. Examples are a leaf at the upper level, a pointer at the lower level, and an entry whose flags are malformed (W set without R). The bench builds small sparse tables in its own memory model, with one lower-level table holding one malformed or restricted entry per page. It then sweeps addresses across those pages with every access kind. The memory responder varies the grant delay and the data delay from one read to the next, so the hold-until-grant rule and the wait for data are both exercised.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int IDX_W = 10;
  localparam int PPN_W = 22;
  localparam int PA_W  = PPN_W + OFF_W;

  typedef enum logic [1:0] {K_FETCH = 2'd0, K_LOAD = 2'd1, K_STORE = 2'd2, K_SPARE = 2'd3} kind_e;
  typedef enum logic [1:0] {C_INVALID = 2'd0, C_NOLEAF = 2'd1, C_PERM = 2'd2} cause_e;
  typedef enum logic [1:0] {VD_LEAF, VD_DESCEND, VD_FAULT} verdict_e;
  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_L1, S_L0, S_DONE} state_e;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic [1:0]       sw;
    logic             d, a, g, u, x, w, r, v;
  } entry_t;

  function automatic logic [PA_W-1:0] f_entry_addr(input logic [PPN_W-1:0] tbl,
                                                   input logic [IDX_W-1:0] idx);
    return {tbl, idx, 2'b00};
  endfunction

  function automatic logic [PA_W-1:0] f_leaf_pa(input logic [PPN_W-1:0] ppn,
                                                input logic [OFF_W-1:0] off);
    return {ppn, off};
  endfunction

  function automatic logic f_malformed(input entry_t e);
    return !e.v || (!e.r && e.w);
  endfunction

  function automatic logic f_pointer(input entry_t e);
    return !e.r && !e.w && !e.x;
  endfunction

  function automatic logic f_allowed(input entry_t e, input kind_e k);
    case (k)
      K_FETCH: return e.r && e.x;
      K_STORE: return e.w;
      default: return e.r;
    endcase
  endfunction
endpackage

// File: rtl/xw_bypass.sv
module xw_bypass
  import xw_pkg::*;
#(
  parameter logic [31:0] PT_BASE   = 32'hF000_0000,
  parameter logic [31:0] BOOT_BASE = 32'h8000_0000,
  parameter logic [31:0] BOOT_SPAN = 32'h0004_0000
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic            paging_on,
  output logic            take
);
  localparam logic [32:0] BOOT_END = {1'b0, BOOT_BASE} + {1'b0, BOOT_SPAN};

  logic in_tables, in_boot;
  assign in_tables = (vaddr >= PT_BASE);
  assign in_boot   = (vaddr >= BOOT_BASE) && ({1'b0, vaddr} < BOOT_END);
  assign take      = !paging_on || in_tables || in_boot;
endmodule

// File: rtl/xw_entry_eval.sv
module xw_entry_eval
  import xw_pkg::*;
(
  input  logic [31:0] raw,
  input  logic        lower_level,
  input  kind_e       kind,
  output verdict_e    verdict,
  output cause_e      cause,
  output logic [PPN_W-1:0] next_ppn
);
  entry_t e;
  logic   unused_bits;
  assign e           = entry_t'(raw);
  assign next_ppn    = e.ppn;
  assign unused_bits = ^{e.sw, e.d, e.a, e.g, e.u};

  always_comb begin
    verdict = VD_LEAF;
    cause   = C_INVALID;
    if (f_malformed(e)) begin
      verdict = VD_FAULT;
      cause   = C_INVALID;
    end else if (f_pointer(e)) begin
      if (lower_level) begin
        verdict = VD_FAULT;
        cause   = C_NOLEAF;
      end else begin
        verdict = VD_DESCEND;
      end
    end else if (!f_allowed(e, kind)) begin
      verdict = VD_FAULT;
      cause   = C_PERM;
    end
  end
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import xw_pkg::*;
#(
  parameter logic [31:0] PT_BASE   = 32'hF000_0000,
  parameter logic [31:0] BOOT_BASE = 32'h8000_0000,
  parameter logic [31:0] BOOT_SPAN = 32'h0004_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic [1:0]  req_kind,
  input  logic [31:0] ctl_word,
  output logic        rsp_valid,
  output logic [33:0] rsp_paddr,
  output logic        rsp_fault,
  output logic [1:0]  rsp_cause,
  output logic        mem_req,
  output logic [33:0] mem_addr,
  input  logic        mem_gnt,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);
  state_e            st;
  logic [VA_W-1:0]   va_q;
  kind_e             kind_q;
  logic [PPN_W-1:0]  root_q;
  logic              on_q;
  logic [PA_W-1:0]   addr_q;
  logic              issued;
  logic [PA_W-1:0]   pa_q;
  logic              fault_q;
  cause_e            cause_q;

  logic              take;
  verdict_e          verdict;
  cause_e            ev_cause;
  logic [PPN_W-1:0]  ent_ppn;
  logic              unused_ctl;

  // named internal events for the checker
  logic ev_bypass, ev_entry, ev_leaf, ev_descend, ev_fault;

  assign unused_ctl = ^ctl_word[30:22];

  xw_bypass #(.PT_BASE(PT_BASE), .BOOT_BASE(BOOT_BASE), .BOOT_SPAN(BOOT_SPAN)) u_byp (
    .vaddr(va_q), .paging_on(on_q), .take(take)
  );

  xw_entry_eval u_eval (
    .raw(mem_rdata), .lower_level(st == S_L0), .kind(kind_q),
    .verdict(verdict), .cause(ev_cause), .next_ppn(ent_ppn)
  );

  assign ev_bypass  = (st == S_CHECK) && take;
  assign ev_entry   = ((st == S_L1) || (st == S_L0)) && issued && mem_rvalid;
  assign ev_leaf    = ev_entry && (verdict == VD_LEAF);
  assign ev_descend = ev_entry && (verdict == VD_DESCEND);
  assign ev_fault   = ev_entry && (verdict == VD_FAULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_q    <= '0;
      kind_q  <= K_LOAD;
      root_q  <= '0;
      on_q    <= 1'b0;
      addr_q  <= '0;
      issued  <= 1'b0;
      pa_q    <= '0;
      fault_q <= 1'b0;
      cause_q <= C_INVALID;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          kind_q <= kind_e'(req_kind);
          root_q <= ctl_word[PPN_W-1:0];
          on_q   <= ctl_word[31];
          st     <= S_CHECK;
        end
        S_CHECK: begin
          if (take) begin
            pa_q    <= {{(PA_W-VA_W){1'b0}}, va_q};
            fault_q <= 1'b0;
            cause_q <= C_INVALID;
            st      <= S_DONE;
          end else begin
            addr_q <= f_entry_addr(root_q, va_q[31:22]);
            issued <= 1'b0;
            st     <= S_L1;
          end
        end
        S_L1, S_L0: begin
          if (!issued && mem_gnt) issued <= 1'b1;
          if (ev_fault) begin
            pa_q    <= '0;
            fault_q <= 1'b1;
            cause_q <= ev_cause;
            st      <= S_DONE;
          end else if (ev_descend) begin
            addr_q <= f_entry_addr(ent_ppn, va_q[21:12]);
            issued <= 1'b0;
            st     <= S_L0;
          end else if (ev_leaf) begin
            pa_q    <= f_leaf_pa(ent_ppn, va_q[OFF_W-1:0]);
            fault_q <= 1'b0;
            cause_q <= C_INVALID;
            st      <= S_DONE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign mem_req   = ((st == S_L1) || (st == S_L0)) && !issued;
  assign mem_addr  = addr_q;
  assign rsp_valid = (st == S_DONE);
  assign rsp_paddr = pa_q;
  assign rsp_fault = fault_q;
  assign rsp_cause = cause_q;
endmodule

// File: rtl/xw_checker.sv
module xw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic [33:0] rsp_paddr,
  input logic        rsp_fault,
  input logic [1:0]  rsp_cause,
  input logic        mem_req,
  input logic [33:0] mem_addr,
  input logic        mem_gnt,
  input logic        ev_bypass,
  input logic [31:0] held_va
);
  a_r10_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

  a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r11_busy_on_reply: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r2_bypass_reply: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bypass |=> rsp_valid && !rsp_fault && rsp_paddr == {2'b00, held_va});

  a_r6_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_paddr[11:0] == held_va[11:0]);

  a_r7_cause_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_cause != 2'd3);
endmodule

bind xlate_walker xw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
  .ev_bypass(ev_bypass), .held_va(va_q)
);

// File: tb/xlate_walker_bench.sv
module xlate_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PTB = 32'hF000_0000;
  localparam logic [31:0] BB  = 32'h8000_0000;
  localparam logic [31:0] BS  = 32'h0004_0000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [31:0] req_vaddr = 0;
  logic [1:0]  req_kind = 0;
  logic [31:0] ctl_word = 0;
  logic rsp_valid, rsp_fault, mem_req;
  logic [33:0] rsp_paddr, mem_addr;
  logic [1:0]  rsp_cause;
  logic mem_gnt = 0, mem_rvalid = 0;
  logic [31:0] mem_rdata = 0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] pmem [longint];
  longint gnt_log [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  xlate_walker #(.PT_BASE(PTB), .BOOT_BASE(BB), .BOOT_SPAN(BS)) u_xlate_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind), .ctl_word(ctl_word),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] rd(input longint a);
    return pmem.exists(a) ? pmem[a] : 32'd0;
  endfunction

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  // memory responder: alternating grant stalls, data delay 0..2 cycles
  initial begin
    automatic bit busy = 0, stall = 0;
    automatic int lat = 0, nreq = 0;
    automatic longint a = 0;
    forever begin
      @(negedge clk);
      mem_gnt = 0; mem_rvalid = 0;
      if (busy) begin
        if (lat == 0) begin mem_rvalid = 1; mem_rdata = rd(a); busy = 0; end
        else lat--;
      end else if (mem_req) begin
        if (stall) stall = 0;
        else begin
          mem_gnt = 1; a = longint'(mem_addr); gnt_log.push_back(a);
          busy = 1; lat = nreq % 3; nreq++; stall = (nreq % 2) == 1;
        end
      end
    end
  end

  // behavioural reference of one translation
  task automatic model(input longint va, input int kind, input longint ctl,
                       output longint pa, output bit f, output int c,
                       output int n, output longint ad [$]);
    longint base, idx, e, ppn;
    bit v, r, w, x, ok;
    ad.delete(); n = 0; f = 0; c = 0; pa = 0;
    if (ctl < 64'h8000_0000 || va >= longint'(PTB) ||
        (va >= longint'(BB) && va < longint'(BB) + longint'(BS))) begin
      pa = va; return;
    end
    base = (ctl % 4194304) * 4096;
    idx  = va / 4194304;
    for (int lvl = 1; lvl >= 0; lvl--) begin
      ad.push_back(base + idx * 4); n++;
      e = longint'(rd(base + idx * 4));
      v = e % 2; r = (e / 2) % 2; w = (e / 4) % 2; x = (e / 8) % 2; ppn = e / 1024;
      if (!v || (!r && w)) begin f = 1; c = 0; return; end
      if (!r && !w && !x) begin
        if (lvl == 0) begin f = 1; c = 1; return; end
        base = ppn * 4096; idx = (va / 4096) % 1024;
      end else begin
        ok = (kind == 0) ? (r && x) : (kind == 2) ? w : r;
        if (!ok) begin f = 1; c = 2; return; end
        pa = ppn * 4096 + va % 4096; return;
      end
    end
  endtask

  task automatic run(input logic [31:0] va, input logic [1:0] kd, input logic [31:0] ctl,
                     input string rq);
    longint pa; bit f; int c, n, cyc; longint ad [$];
    model(longint'(va), int'(kd), longint'(ctl), pa, f, c, n, ad);
    gnt_log.delete();
    @(negedge clk);
    req_vaddr = va; req_kind = kd; ctl_word = ctl; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R11 ready low while busy", req_ready, 0);
    cyc = 1;
    while (!rsp_valid && cyc < 100) begin @(negedge clk); cyc++; end
    chk(rsp_valid == 1, {rq, " response seen"}, rsp_valid, 1);
    if (n == 0) chk(cyc == 2, "R2 bypass latency", cyc, 2);
    chk(rsp_fault == f, {rq, " fault flag"}, rsp_fault, f);
    chk(rsp_paddr == pa[33:0], {rq, " paddr"}, rsp_paddr, pa);
    if (f) chk(rsp_cause == c[1:0], {rq, " cause"}, rsp_cause, c);
    chk(gnt_log.size() == n, "R10 read count", gnt_log.size(), n);
    if (n >= 1 && gnt_log.size() >= 1) chk(gnt_log[0] == ad[0], "R4 first entry address", gnt_log[0], ad[0]);
    if (n == 2 && gnt_log.size() == 2) chk(gnt_log[1] == ad[1], "R5 second entry address", gnt_log[1], ad[1]);
    @(negedge clk);
    chk(rsp_valid == 0, "R11 single pulse", rsp_valid, 0);
  endtask

  localparam logic [31:0] ON  = 32'h8000_0123;
  localparam logic [31:0] ON2 = 32'h8000_0200;

  function automatic logic [31:0] pte(input longint ppn, input int flags);
    return 32'(ppn * 1024 + flags);
  endfunction

  initial begin
    // tables: root 0x123, pointer at vpn1 0x41 to table 0x456
    pmem[64'h123000 + 64'h41 * 4] = pte(64'h456, 1);
    pmem[64'h456000 + 5 * 4]  = pte(64'h2ABCDE, 8'hCF);
    pmem[64'h456000 + 6 * 4]  = pte(64'h777, 8'h03);
    pmem[64'h456000 + 7 * 4]  = pte(64'h778, 8'h05);
    pmem[64'h456000 + 8 * 4]  = pte(64'h999, 8'h01);
    pmem[64'h456000 + 9 * 4]  = pte(64'h1234, 8'h0E);
    pmem[64'h456000 + 10 * 4] = pte(64'h3FFFFF, 8'h09);
    pmem[64'h123000 + 64'h42 * 4] = pte(64'h1F00, 8'h07);
    pmem[64'h200000 + 64'h41 * 4] = pte(64'h55, 8'h0B);

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
    chk(rsp_valid == 0, "R1 no response after reset", rsp_valid, 0);
    chk(mem_req == 0, "R1 no read after reset", mem_req, 0);

    run(32'h1040_5ABC, 2'd1, 32'h0000_0123, "R2 paging off");
    run(32'hFFFF_FFFF, 2'd2, 32'h7FFF_FFFF, "R2 paging off top");
    run(32'h1040_5ABC, 2'd1, ON, "R6 two-level leaf");
    run(32'h1040_5000, 2'd0, ON, "R9 fetch RX ok");
    run(32'h1040_6123, 2'd1, ON, "R9 load R-only ok");
    run(32'h1040_6123, 2'd2, ON, "R9 store R-only");
    run(32'h1040_6123, 2'd0, ON, "R9 fetch no X");
    run(32'h1040_A010, 2'd0, ON, "R9 fetch X-only");
    run(32'h1040_A010, 2'd3, ON, "R9 kind3 as load");
    run(32'h1040_7FFF, 2'd1, ON, "R7 W without R");
    run(32'h1040_9004, 2'd1, ON, "R7 V clear leaf");
    run(32'h10C0_1234, 2'd1, ON, "R7 V clear upper");
    run(32'h1040_8008, 2'd1, ON, "R8 pointer at lower level");
    run(32'h1080_0FED, 2'd2, ON, "R6 upper-level leaf");
    run(32'h1040_0ABC, 2'd0, ON2, "R4 other root");
    run(PTB - 1, 2'd1, ON, "R3 below table base");
    run(PTB, 2'd1, ON, "R3 table base");
    run(BB - 1, 2'd1, ON, "R3 below boot window");
    run(BB, 2'd0, ON, "R3 boot start");
    run(BB + BS - 1, 2'd2, ON, "R3 boot last");
    run(BB + BS, 2'd1, ON, "R3 past boot window");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule